// File: doc/BRIEF.md
# Clock Enable Prescaler with Double-Speed Mode

This block runs entirely on the oscillator clock and produces single-cycle enable strobes: one for the processor core and one per peripheral. A front-end divide-by-2 phase sets the base rate in standard mode. A double-speed request removes that halving. The request is only accepted on cycles where the divide-by-2 phase is high, so the enable pattern never shows a partial step when the mode changes.

An 8-bit reload value controls a programmable divider behind the front end. The all-ones code bypasses the divider. Any other value divides the base rate by twice the distance from all-ones. A new reload value is sampled only when the divider reaches terminal count, so a running period always completes with the value it started with.

Each peripheral has a rate-select bit. In double-speed mode a set bit halves that peripheral's rate relative to the core. In standard mode the bit is ignored.

Top module: `clkpre_top`

## Requirements
- R1: While `rst_n` is low, `cpu_en_o` and every bit of `periph_en_o` are 0. In the cycle right after reset is released, `cpu_en_o` is 0. With reload 8'hFF and standard mode, the first core strobe comes in the following cycle.
- R2: With reload 8'hFF in standard mode, `cpu_en_o` is a one-cycle pulse every 2 clock cycles.
- R3: With reload 8'hFF in double-speed mode, `cpu_en_o` is high in every clock cycle.
- R4: With reload r != 8'hFF in standard mode, `cpu_en_o` pulses once every 4*(255-r) clock cycles.
- R5: With reload r != 8'hFF in double-speed mode, `cpu_en_o` pulses once every 2*(255-r) clock cycles.
- R6: Reload 8'h00 gives the longest periods: 1020 cycles in standard mode and 510 cycles in double-speed mode.
- R7: A change of `x2_req_i` becomes active only at a clock edge where the internal divide-by-2 phase is high. Once active, it gives the period of the new mode.
- R8: In double-speed mode, a peripheral whose `periph_slow_i` bit is 1 strobes on every second core strobe. A peripheral whose bit is 0 strobes together with every core strobe. A peripheral strobe never occurs without a core strobe.
- R9: In standard mode, `periph_slow_i` has no effect: every peripheral strobes together with every core strobe.
- R10: A reload value changed in the middle of a divider period does not alter that period. The new value takes effect from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_req_i | input | 1 | Double-speed mode request (1 = double speed) |
| reload_i | input | 8 | Divider reload value; 8'hFF bypasses the divider |
| periph_slow_i | input | NPER | Per-peripheral rate select (1 = half rate in double-speed mode) |
| cpu_en_o | output | 1 | Core clock-enable strobe |
| periph_en_o | output | NPER | Peripheral clock-enable strobes |

## Verification
Every output is decoded directly from registers, so a strobe shows in the same cycle as the register state that causes it. A mode request takes effect at most two edges later. A reload change shows after the current period ends, which can be up to 1020 cycles. The bench samples on the falling edge. After each change it lets three core strobes go by before it measures intervals, counted in rising edges, between consecutive strobes. The mid-period reload test and the mode-switch test time their stimulus relative to an observed strobe, so each expected value is fixed to an exact cycle.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

   // Count value loaded into the divider at terminal count.
   // Bypass code (all ones) loads zero so every base tick is terminal.
   function automatic logic [8:0] reload_to_count(input logic [7:0] r);
      logic [8:0] span;
      if (&r) begin
         reload_to_count = '0;
      end else begin
         span = {~r, 1'b0};
         reload_to_count = span - 9'd1;
      end
   endfunction

endpackage

// File: rtl/clkpre_front.sv
module clkpre_front (
   input  logic clk,
   input  logic rst_n,
   input  logic x2_req_i,
   output logic base_tick_o,
   output logic half_o,
   output logic x2_act_o
);
   logic half_q;
   logic x2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         x2_q   <= 1'b0;
      end else begin
         half_q <= ~half_q;
         // mode accepted only while the divide-by-2 phase is high
         if (half_q) x2_q <= x2_req_i;
      end
   end

   assign base_tick_o = x2_q | half_q;
   assign half_o      = half_q;
   assign x2_act_o    = x2_q;
endmodule

// File: rtl/clkpre_div.sv
module clkpre_div #(
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [RW-1:0] reload_i,
   output logic          strobe_o
);
   import clkpre_pkg::*;
   localparam int CW = RW + 1;

   logic [CW-1:0] cnt_q;
   logic          term;

   assign term     = tick_i && (cnt_q == '0);
   assign strobe_o = term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (term) begin
         cnt_q <= reload_to_count(reload_i);
      end else if (tick_i) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/clkpre_periph.sv
module clkpre_periph #(
   parameter int NPER    = 4,
   parameter bit SEL_POL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_en_i,
   input  logic            x2_act_i,
   input  logic [NPER-1:0] sel_i,
   output logic [NPER-1:0] en_o
);
   logic            phase_q;
   logic [NPER-1:0] half_rate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase_q <= 1'b0;
      else if (cpu_en_i) phase_q <= ~phase_q;
   end

   generate
      if (SEL_POL) begin : g_pos
         assign half_rate = sel_i;
      end else begin : g_neg
         assign half_rate = ~sel_i;
      end
   endgenerate

   for (genvar i = 0; i < NPER; i++) begin : g_ch
      assign en_o[i] = cpu_en_i && (!x2_act_i || !half_rate[i] || phase_q);
   end
endmodule

// File: rtl/clkpre_top.sv
module clkpre_top #(
   parameter int NPER = 4,
   parameter int RW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            x2_req_i,
   input  logic [RW-1:0]   reload_i,
   input  logic [NPER-1:0] periph_slow_i,
   output logic            cpu_en_o,
   output logic [NPER-1:0] periph_en_o
);
   generate
      if (NPER < 1) begin : g_bad_nper
         $error("NPER must be at least 1");
      end
      if (RW != 8) begin : g_bad_rw
         $error("RW must be 8");
      end
   endgenerate

   logic base_tick;
   logic half_phase;
   logic x2_act;

   clkpre_front u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .x2_req_i   (x2_req_i),
      .base_tick_o(base_tick),
      .half_o     (half_phase),
      .x2_act_o   (x2_act)
   );

   clkpre_div #(.RW(RW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (base_tick),
      .reload_i(reload_i),
      .strobe_o(cpu_en_o)
   );

   clkpre_periph #(.NPER(NPER), .SEL_POL(1'b1)) u_periph (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_en_i(cpu_en_o),
      .x2_act_i(x2_act),
      .sel_i   (periph_slow_i),
      .en_o    (periph_en_o)
   );
endmodule

// File: rtl/clkpre_chk.sv
module clkpre_chk #(
   parameter int NPER = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            x2_req_i,
   input logic            half_phase,
   input logic            x2_act,
   input logic            cpu_en_o,
   input logic [NPER-1:0] periph_en_o
);
   // R7
   mode_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(x2_act) |-> $past(half_phase));

   // R8
   periph_within_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_en_o) |-> cpu_en_o);

   // R9
   std_all_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en_o && !x2_act) |-> (&periph_en_o));

   // R2
   std_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en_o && !x2_act && !x2_req_i) |=> !cpu_en_o);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!cpu_en_o && periph_en_o == '0));
endmodule

bind clkpre_top clkpre_chk #(.NPER(NPER)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .x2_req_i   (x2_req_i),
   .half_phase (half_phase),
   .x2_act     (x2_act),
   .cpu_en_o   (cpu_en_o),
   .periph_en_o(periph_en_o)
);

// File: tb/clkpre_top_tb.sv
module clkpre_top_tb;
   localparam int NPER = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            x2_req = 1'b0;
   logic [7:0]      reload = 8'hFF;
   logic [NPER-1:0] slow = '0;
   logic            cpu_en;
   logic [NPER-1:0] periph_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   clkpre_top #(.NPER(NPER), .RW(8)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .x2_req_i     (x2_req),
      .reload_i     (reload),
      .periph_slow_i(slow),
      .cpu_en_o     (cpu_en),
      .periph_en_o  (periph_en)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cpu();
      do @(negedge clk); while (!cpu_en);
   endtask

   task automatic wait_per(input int idx);
      do @(negedge clk); while (!periph_en[idx]);
   endtask

   task automatic settle();
      repeat (3) wait_cpu();
   endtask

   task automatic cpu_period(output int p);
      int t0;
      wait_cpu();
      t0 = cyc;
      wait_cpu();
      p = cyc - t0;
   endtask

   task automatic per_period(input int idx, output int p);
      int t0;
      wait_per(idx);
      t0 = cyc;
      wait_per(idx);
      p = cyc - t0;
   endtask

   task automatic set_and_check(input string req, input bit x2, input logic [7:0] r, input int exp);
      int p;
      x2_req = x2;
      reload = r;
      settle();
      cpu_period(p);
      check(req, p, exp);
      cpu_period(p);
      check(req, p, exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 cpu_en in reset", int'(cpu_en), 0);
      check("R1 periph_en in reset", int'(periph_en), 0);
      rst_n = 1'b1;
      #1;
      check("R1 cpu_en right after release", int'(cpu_en), 0);
      @(negedge clk);
      check("R1 first strobe", int'(cpu_en), 1);
   endtask

   task automatic t_bypass();
      set_and_check("R2 std bypass period", 1'b0, 8'hFF, 2);
      set_and_check("R3 x2 bypass period", 1'b1, 8'hFF, 1);
   endtask

   task automatic t_divided();
      set_and_check("R4 std r=FE", 1'b0, 8'hFE, 4);
      set_and_check("R4 std r=80", 1'b0, 8'h80, 4 * 127);
      set_and_check("R5 x2 r=FE", 1'b1, 8'hFE, 2);
      set_and_check("R5 x2 r=F0", 1'b1, 8'hF0, 30);
   endtask

   task automatic t_extremes();
      set_and_check("R6 std r=00", 1'b0, 8'h00, 1020);
      set_and_check("R6 x2 r=00", 1'b1, 8'h00, 510);
   endtask

   task automatic t_mode_switch();
      int p;
      x2_req = 1'b0;
      reload = 8'hFF;
      settle();
      wait_cpu();
      @(negedge clk);
      x2_req = 1'b1;
      @(negedge clk);
      check("R7 strobe on phase edge", int'(cpu_en), 1);
      @(negedge clk);
      check("R7 double speed active", int'(cpu_en), 1);
      cpu_period(p);
      check("R7 x2 period", p, 1);
      x2_req = 1'b0;
      settle();
      cpu_period(p);
      check("R7 back to std period", p, 2);
   endtask

   task automatic t_periph();
      int p;
      x2_req = 1'b1;
      reload = 8'hFF;
      slow = 4'b0101;
      settle();
      per_period(0, p);
      check("R8 slow periph0 period", p, 2);
      per_period(1, p);
      check("R8 fast periph1 period", p, 1);
      reload = 8'hFE;
      settle();
      per_period(2, p);
      check("R8 slow periph2 divided", p, 4);
      per_period(3, p);
      check("R8 fast periph3 divided", p, 2);
      x2_req = 1'b0;
      reload = 8'hFF;
      slow = 4'b1111;
      settle();
      per_period(0, p);
      check("R9 std ignores select p0", p, 2);
      per_period(3, p);
      check("R9 std ignores select p3", p, 2);
      wait_cpu();
      check("R9 all periph with cpu", int'(periph_en), 15);
      slow = '0;
   endtask

   task automatic t_midreload();
      int t0;
      int p;
      x2_req = 1'b0;
      reload = 8'h80;
      settle();
      wait_cpu();
      t0 = cyc;
      repeat (100) @(negedge clk);
      reload = 8'hFE;
      wait_cpu();
      check("R10 running period kept", cyc - t0, 508);
      cpu_period(p);
      check("R10 new period applied", p, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_bypass();
      t_divided();
      t_extremes();
      t_mode_switch();
      t_periph();
      t_midreload();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule